// File: doc/BRIEF.md
# Multi-Cycle Processor Datapath

This block is the datapath of a small 32-bit load/store processor that spreads each instruction over several short clock cycles. It contains the program counter, a 32-entry register file, one ALU, an immediate extender and five staging registers: instruction, operand A, operand B, ALU result and memory data. Each staging register has its own load enable. A slow step such as a register-file read, an ALU operation or a memory access therefore finishes in its own cycle, and the result is held for the next step.

The block makes no sequencing decisions. An external controller drives every register enable, every multiplexer select, the ALU function and every write strobe. The controller decodes the instruction from `ir_o` and takes the operand-equality flag `eq_o` to resolve branches. The block drives an instruction-memory address and reads the returned word. It also drives a data-memory address, write data and write strobe, and reads the returned data. A typical controller runs fetch, operand read, execute, optional memory access and write-back. With that sequence the block executes register-register ALU ops, OR-immediate, load word, store word and branch-if-equal.

Top module: `mc_datapath`

## Requirements
- R1: While `rst_ni` is low, the PC and all staging registers are cleared. After release, `imem_addr_o`, `ir_o`, `dmem_addr_o` and `dmem_wdata_o` read 0 and `eq_o` reads 1.
- R2: When `ir_en_i` is high at a rising edge, the instruction register loads `imem_rdata_i`, and otherwise it holds its value. `imem_addr_o` always shows the PC. The instruction fields are rs = bits 25:21, rt = bits 20:16, rd = bits 15:11 and immediate = bits 15:0.
- R3: When `a_en_i` is high, operand A loads the register addressed by rs. When `b_en_i` is high, operand B loads the register addressed by rt. Each holds its value otherwise. B is visible on `dmem_wdata_o`, and `eq_o` is high exactly when A equals B.
- R4: When `r_en_i` is high, the result register loads the ALU output, and otherwise it holds its value. `alu_fn_i` selects the function: 0 add, 1 subtract, 2 AND, 3 OR, 4 signed set-less-than, which gives 1 or 0. Codes 5 to 7 give 0. The first ALU operand is A. The second is B when `alu_src_imm_i` is 0 and the extended immediate when it is 1.
- R5: The immediate is zero-extended when `ext_sign_i` is 0 and sign-extended when it is 1.
- R6: `dmem_addr_o` shows the result register. When `m_en_i` is high, the memory data register loads `dmem_rdata_i`.
- R7: When `reg_we_i` is high, the register file writes at the rising edge. The destination is rd when `reg_dst_rd_i` is 1 and rt when it is 0. The data is the memory data register when `wb_sel_mem_i` is 1 and the result register when it is 0.
- R8: Register 0 always reads as zero, and writes to it have no effect.
- R9: When `pc_en_i` is high and `pc_branch_i` is 0, the PC becomes PC+4. When `pc_en_i` is high and `pc_branch_i` is 1, the PC becomes PC+4 plus the sign-extended immediate shifted left by two. When `pc_en_i` is low, the PC holds its value.
- R10: `dmem_we_o` follows `mem_we_i` in the same cycle. During a store the address is the result register and the data is operand B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 32 | Instruction fetch address (PC) |
| imem_rdata_i | input | 32 | Instruction word from memory |
| ir_o | output | 32 | Instruction register, for the controller to decode |
| eq_o | output | 1 | Operand A equals operand B |
| dmem_addr_o | output | 32 | Data memory address (result register) |
| dmem_wdata_o | output | 32 | Data memory write data (operand B) |
| dmem_we_o | output | 1 | Data memory write strobe |
| dmem_rdata_i | input | 32 | Data memory read data |
| ir_en_i | input | 1 | Load instruction register |
| a_en_i | input | 1 | Load operand A |
| b_en_i | input | 1 | Load operand B |
| r_en_i | input | 1 | Load result register |
| m_en_i | input | 1 | Load memory data register |
| pc_en_i | input | 1 | Update PC |
| pc_branch_i | input | 1 | PC update uses branch target |
| alu_src_imm_i | input | 1 | Second ALU operand is the extended immediate |
| ext_sign_i | input | 1 | Sign-extend (1) or zero-extend (0) the immediate |
| alu_fn_i | input | 3 | ALU function code |
| reg_dst_rd_i | input | 1 | Write destination is rd (1) or rt (0) |
| wb_sel_mem_i | input | 1 | Write data comes from memory data register |
| reg_we_i | input | 1 | Register file write enable |
| mem_we_i | input | 1 | Store request |

## Verification
The bench targets immediate 0x8000 under both extension modes. A swapped extender gives OR-immediate a negative operand or gives a load address in the wrong half of the address space. It also writes to register 0 and reads the register back. A design that stores into register 0 returns a nonzero operand and a nonzero OR result. Signed set-less-than is tested with a negative versus a positive operand, where an unsigned compare returns the wrong bit. Backward taken branches and held enables are exercised as well. A broken offset shift lands the PC on the wrong word, and a leaky enable changes the result or instruction register in a cycle where the controller did not ask for it.

// File: rtl/mc_dp_pkg.sv
`timescale 1ns/1ps
package mc_dp_pkg;
  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_fn_e;

  localparam int IMM_W   = 16;
  localparam int RS_LSB  = 21;
  localparam int RT_LSB  = 16;
  localparam int RD_LSB  = 11;
  localparam int PC_STEP = 4;
endpackage

// File: rtl/mc_regfile.sv
`timescale 1ns/1ps
module mc_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int RAW  = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RAW-1:0]  ra_i,
  input  logic [RAW-1:0]  rb_i,
  output logic [XLEN-1:0] rdata_a_o,
  output logic [XLEN-1:0] rdata_b_o,
  input  logic            we_i,
  input  logic [RAW-1:0]  wa_i,
  input  logic [XLEN-1:0] wd_i
);
  logic [XLEN-1:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      // hardwired zero, writes dropped
      assign regs[g] = '0;
    end else begin : g_store
      logic [XLEN-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                         q <= '0;
        else if (we_i && wa_i == RAW'(g))    q <= wd_i;
      end
      assign regs[g] = q;
    end
  end

  assign rdata_a_o = regs[ra_i];
  assign rdata_b_o = regs[rb_i];
endmodule

// File: rtl/mc_ext.sv
`timescale 1ns/1ps
module mc_ext #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic             sign_i,
  output logic [XLEN-1:0]  y_o
);
  logic fill;
  assign fill = sign_i & imm_i[IMM_W-1];
  assign y_o  = {{(XLEN-IMM_W){fill}}, imm_i};
endmodule

// File: rtl/mc_alu.sv
`timescale 1ns/1ps
module mc_alu
  import mc_dp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [2:0]      fn_i,
  output logic [XLEN-1:0] y_o
);
  alu_fn_e fn;
  assign fn = alu_fn_e'(fn_i);

  always_comb begin
    unique case (fn)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = XLEN'($signed(a_i) < $signed(b_i));
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_datapath.sv
`timescale 1ns/1ps
module mc_datapath
  import mc_dp_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic [XLEN-1:0] imem_rdata_i,
  output logic [XLEN-1:0] ir_o,
  output logic            eq_o,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  output logic            dmem_we_o,
  input  logic [XLEN-1:0] dmem_rdata_i,
  input  logic            ir_en_i,
  input  logic            a_en_i,
  input  logic            b_en_i,
  input  logic            r_en_i,
  input  logic            m_en_i,
  input  logic            pc_en_i,
  input  logic            pc_branch_i,
  input  logic            alu_src_imm_i,
  input  logic            ext_sign_i,
  input  logic [2:0]      alu_fn_i,
  input  logic            reg_dst_rd_i,
  input  logic            wb_sel_mem_i,
  input  logic            reg_we_i,
  input  logic            mem_we_i
);
  localparam int RAW = $clog2(NREGS);

  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, r_q, m_q;
  logic [XLEN-1:0] rf_a, rf_b, rf_wd, alu_b, alu_y, imm_ext, imm_sx, pc_inc, pc_nxt;
  logic [RAW-1:0]  rs, rt, rd, rf_wa;
  logic [IMM_W-1:0] imm;

  assign rs  = ir_q[RS_LSB +: RAW];
  assign rt  = ir_q[RT_LSB +: RAW];
  assign rd  = ir_q[RD_LSB +: RAW];
  assign imm = ir_q[IMM_W-1:0];

  mc_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ra_i     (rs),
    .rb_i     (rt),
    .rdata_a_o(rf_a),
    .rdata_b_o(rf_b),
    .we_i     (reg_we_i),
    .wa_i     (rf_wa),
    .wd_i     (rf_wd)
  );

  mc_ext #(.XLEN(XLEN), .IMM_W(IMM_W)) u_ext_op (
    .imm_i (imm),
    .sign_i(ext_sign_i),
    .y_o   (imm_ext)
  );

  // branch offset is always signed, independent of the operand extender
  mc_ext #(.XLEN(XLEN), .IMM_W(IMM_W)) u_ext_br (
    .imm_i (imm),
    .sign_i(1'b1),
    .y_o   (imm_sx)
  );

  assign alu_b = alu_src_imm_i ? imm_ext : b_q;

  mc_alu #(.XLEN(XLEN)) u_alu (
    .a_i (a_q),
    .b_i (alu_b),
    .fn_i(alu_fn_i),
    .y_o (alu_y)
  );

  assign rf_wa  = reg_dst_rd_i ? rd : rt;
  assign rf_wd  = wb_sel_mem_i ? m_q : r_q;
  assign pc_inc = pc_q + XLEN'(PC_STEP);
  assign pc_nxt = pc_branch_i ? pc_inc + {imm_sx[XLEN-3:0], 2'b00} : pc_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      r_q  <= '0;
      m_q  <= '0;
    end else begin
      if (pc_en_i) pc_q <= pc_nxt;
      if (ir_en_i) ir_q <= imem_rdata_i;
      if (a_en_i)  a_q  <= rf_a;
      if (b_en_i)  b_q  <= rf_b;
      if (r_en_i)  r_q  <= alu_y;
      if (m_en_i)  m_q  <= dmem_rdata_i;
    end
  end

  assign imem_addr_o  = pc_q;
  assign ir_o         = ir_q;
  assign eq_o         = (a_q == b_q);
  assign dmem_addr_o  = r_q;
  assign dmem_wdata_o = b_q;
  assign dmem_we_o    = mem_we_i;
endmodule

// File: rtl/mc_datapath_chk.sv
`timescale 1ns/1ps
module mc_datapath_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] imem_addr_o,
  input logic [XLEN-1:0] imem_rdata_i,
  input logic [XLEN-1:0] ir_o,
  input logic [XLEN-1:0] dmem_addr_o,
  input logic [XLEN-1:0] dmem_wdata_o,
  input logic            ir_en_i,
  input logic            b_en_i,
  input logic            r_en_i,
  input logic            pc_en_i,
  input logic            pc_branch_i
);
  p_ir_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_en_i |=> ir_o == $past(imem_rdata_i));

  p_ir_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ir_en_i |=> $stable(ir_o));

  p_b_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_en_i |=> $stable(dmem_wdata_o));

  p_r_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_en_i |=> $stable(dmem_addr_o));

  p_pc_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_en_i |=> $stable(imem_addr_o));

  p_pc_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_en_i && !pc_branch_i) |=> imem_addr_o == $past(imem_addr_o) + XLEN'(4));
endmodule

bind mc_datapath mc_datapath_chk #(.XLEN(XLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .imem_addr_o (imem_addr_o),
  .imem_rdata_i(imem_rdata_i),
  .ir_o        (ir_o),
  .dmem_addr_o (dmem_addr_o),
  .dmem_wdata_o(dmem_wdata_o),
  .ir_en_i     (ir_en_i),
  .b_en_i      (b_en_i),
  .r_en_i      (r_en_i),
  .pc_en_i     (pc_en_i),
  .pc_branch_i (pc_branch_i)
);

// File: tb/mc_datapath_tb_top.sv
`timescale 1ns/1ps
module mc_datapath_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [31:0] imem_addr_o, imem_rdata_i, ir_o, dmem_addr_o, dmem_wdata_o, dmem_rdata_i;
  logic        eq_o, dmem_we_o;
  logic        ir_en_i, a_en_i, b_en_i, r_en_i, m_en_i, pc_en_i, pc_branch_i;
  logic        alu_src_imm_i, ext_sign_i, reg_dst_rd_i, wb_sel_mem_i, reg_we_i, mem_we_i;
  logic [2:0]  alu_fn_i;

  always #5 clk_i = ~clk_i;

  mc_datapath dut_i (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] mrf [32];
  logic [31:0] mpc, ma, mb, mr, mm, cur;

  function automatic logic [31:0] sx(input logic [15:0] i);
    return {{16{i[15]}}, i};
  endfunction

  function automatic logic [31:0] alu_ref(input logic [2:0] fn, input logic [31:0] a, b);
    case (fn)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return {31'd0, $signed(a) < $signed(b)};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    {ir_en_i, a_en_i, b_en_i, r_en_i, m_en_i, pc_en_i, pc_branch_i} = '0;
    {alu_src_imm_i, ext_sign_i, reg_dst_rd_i, wb_sel_mem_i, reg_we_i, mem_we_i} = '0;
    alu_fn_i = 3'd0;
  endtask

  task automatic tick();
    @(posedge clk_i); #2; clr();
  endtask

  task automatic fetch(input logic [31:0] ins);
    imem_rdata_i = ins; ir_en_i = 1'b1; tick();
    cur = ins;
    chk("R2", "ir", ir_o, ins);
    chk("R2", "pc", imem_addr_o, mpc);
  endtask

  task automatic ops();
    a_en_i = 1'b1; b_en_i = 1'b1; tick();
    ma = mrf[cur[25:21]]; mb = mrf[cur[20:16]];
    chk("R3", "B", dmem_wdata_o, mb);
    chk("R3", "eq", {31'd0, eq_o}, {31'd0, ma == mb});
  endtask

  task automatic exec(input logic [2:0] fn, input bit imm, input bit sgn);
    logic [31:0] e;
    alu_fn_i = fn; alu_src_imm_i = imm; ext_sign_i = sgn; r_en_i = 1'b1; tick();
    e  = sgn ? sx(cur[15:0]) : {16'd0, cur[15:0]};
    mr = alu_ref(fn, ma, imm ? e : mb);
    chk(imm ? "R5" : "R4", "alu result", dmem_addr_o, mr);
  endtask

  task automatic wb(input bit to_rd, input bit from_mem);
    logic [4:0] dst;
    reg_we_i = 1'b1; reg_dst_rd_i = to_rd; wb_sel_mem_i = from_mem; pc_en_i = 1'b1; tick();
    dst = to_rd ? cur[15:11] : cur[20:16];
    if (dst != 5'd0) mrf[dst] = from_mem ? mm : mr;  // R7, R8
    mpc = mpc + 32'd4;
    chk("R9", "pc step", imem_addr_o, mpc);
  endtask

  task automatic do_rtype(input logic [4:0] rs, rt, rd, input logic [2:0] fn);
    fetch({6'h00, rs, rt, rd, 5'd0, 6'h20}); ops(); exec(fn, 1'b0, 1'b0); wb(1'b1, 1'b0);
  endtask

  task automatic do_ori(input logic [4:0] rs, rt, input logic [15:0] imm);
    fetch({6'h0d, rs, rt, imm}); ops(); exec(3'd3, 1'b1, 1'b0); wb(1'b0, 1'b0);
  endtask

  task automatic do_lw(input logic [4:0] rs, rt, input logic [15:0] imm, input logic [31:0] data);
    fetch({6'h23, rs, rt, imm}); ops(); exec(3'd0, 1'b1, 1'b1);
    dmem_rdata_i = data; m_en_i = 1'b1; tick();
    mm = data;
    chk("R6", "addr held", dmem_addr_o, mr);
    wb(1'b0, 1'b1);
  endtask

  task automatic do_sw(input logic [4:0] rs, rt, input logic [15:0] imm);
    fetch({6'h2b, rs, rt, imm}); ops(); exec(3'd0, 1'b1, 1'b1);
    mem_we_i = 1'b1; pc_en_i = 1'b1; #1;
    chk("R10", "we", {31'd0, dmem_we_o}, 32'd1);
    chk("R10", "st addr", dmem_addr_o, mr);
    chk("R10", "st data", dmem_wdata_o, mb);
    tick();
    chk("R10", "we off", {31'd0, dmem_we_o}, 32'd0);
    mpc = mpc + 32'd4;
    chk("R9", "pc step", imem_addr_o, mpc);
  endtask

  task automatic do_beq(input logic [4:0] rs, rt, input logic [15:0] imm);
    bit tk;
    fetch({6'h04, rs, rt, imm}); ops();
    tk = (ma == mb);
    pc_en_i = 1'b1; pc_branch_i = tk; tick();
    mpc = mpc + 32'd4 + (tk ? {sx(imm)[29:0], 2'b00} : 32'd0);
    chk("R9", tk ? "branch taken" : "branch not taken", imem_addr_o, mpc);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] seed_v, hold_r, hold_ir;
    seed_v = $urandom(32'h5eed_1234);
    clr(); imem_rdata_i = '0; dmem_rdata_i = '0; rst_ni = 1'b0;
    for (int i = 0; i < 32; i++) mrf[i] = '0;
    mpc = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1; #1;
    chk("R1", "pc", imem_addr_o, 0);
    chk("R1", "ir", ir_o, 0);
    chk("R1", "R", dmem_addr_o, 0);
    chk("R1", "B", dmem_wdata_o, 0);
    chk("R1", "eq", {31'd0, eq_o}, 32'd1);

    // R5: 0x8000 zero-extended for OR-immediate, sign-extended for address
    do_ori(5'd0, 5'd1, 16'h8000);
    do_lw(5'd0, 5'd2, 16'h8000, 32'hdead_beef);
    // R8: write to r0 dropped
    do_ori(5'd0, 5'd0, 16'h1234);
    do_rtype(5'd0, 5'd0, 5'd3, 3'd3);
    chk("R8", "r0 or r0", dmem_addr_o, 32'd0);
    // R4: signed compare, negative vs positive
    do_rtype(5'd2, 5'd1, 5'd4, 3'd4);
    chk("R4", "slt neg<pos", dmem_addr_o, 32'd1);
    do_rtype(5'd1, 5'd2, 5'd5, 3'd4);
    do_rtype(5'd1, 5'd2, 5'd6, 3'd5);
    do_rtype(5'd2, 5'd1, 5'd7, 3'd1);
    // R7: rd vs rt destination checked through later reads
    do_rtype(5'd7, 5'd0, 5'd8, 3'd0);
    // R4/R2 hold when enables are low
    hold_r = dmem_addr_o; hold_ir = ir_o;
    alu_fn_i = 3'd1; imem_rdata_i = 32'h0bad_f00d; tick();
    chk("R4", "R hold", dmem_addr_o, hold_r);
    chk("R2", "ir hold", ir_o, hold_ir);
    // R9: taken backward branch, not taken forward
    do_beq(5'd1, 5'd1, 16'hfff0);
    do_beq(5'd1, 5'd2, 16'h0010);
    do_sw(5'd1, 5'd2, 16'hfffc);

    for (int k = 0; k < 400; k++) begin
      logic [4:0] rs, rt, rd;
      logic [15:0] imm;
      rs = 5'($urandom); rt = 5'($urandom); rd = 5'($urandom); imm = 16'($urandom);
      case ($urandom % 5)
        0: do_rtype(rs, rt, rd, 3'($urandom % 6));
        1: do_ori(rs, rt, imm);
        2: do_lw(rs, rt, imm, $urandom);
        3: do_sw(rs, rt, imm);
        default: do_beq(rs, ($urandom % 3 == 0) ? rs : rt, imm);
      endcase
    end
    finish_run();
  end
endmodule